// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block produces the refresh sequence for a dot-matrix panel with 64 common rows and 128 segment columns, driven at 1/64 duty. It runs from the oscillator clock. A divider turns that clock into a line clock, and one common row is selected in each line period. For every row the block fetches one RAM line from an external synchronous memory port, in two 64-bit halves. It holds the 128 segment bits for the whole line and toggles a frame alternation signal once per frame, so that the analog driver can reverse polarity.

A 6-bit line counter maps rows to RAM lines. Just before the first common row of each frame, the counter is loaded from the start-line input, and it then advances once per row. Changing the start line therefore scrolls the picture vertically with no RAM traffic beyond the normal refresh. Two strap-style inputs reverse the direction in which the common select moves and the order in which the columns of each half reach the segment pins. A display-enable input forces every segment to the non-select level while the scan keeps running.

The outputs are digital select codes. A high `comSel` bit marks the selected common, and a high `segOn` bit marks a segment driven to its select level. The analog stage combines these with `acPhase` to pick the voltages.

Top module: `lcd_row_scan`

## Requirements
- R1: `comSel` is all zero from reset until the first line boundary. From then on, exactly one bit of `comSel` is high at all times.
- R2: Line boundaries recur every 96 clock cycles when `fastSel` is 1 and every 48 cycles when it is 0.
- R3: The first row after each frame boundary (scan position 0) shows RAM line `startLine`, as sampled when that row's first RAM request is issued. Scan position k then shows line (start + k) mod 64.
- R4: `comSel` and the latched segment data change together, at the same clock edge at each line boundary, and they are held for the rest of the line.
- R5: With `comDir` = 1, scan position k selects `comSel[k]`. With `comDir` = 0, it selects `comSel[63-k]`.
- R6: Bit c of the half-h RAM word (h = 0 or 1) drives `segOn[64*h + c]` when `segDir` = 1, and drives `segOn[64*h + 63 - c]` when `segDir` = 0.
- R7: `lineClk` is high while the divider sits in the first half of its count. A line boundary coincides with a rising edge of `lineClk` when `shiftEdge` = 1 and with a falling edge when `shiftEdge` = 0.
- R8: While `dispOn` = 0, every `segOn` bit is 0 and the common scan continues. When `dispOn` is raised mid-line, the current line's data reappears at once, with no new RAM read.
- R9: `acPhase` inverts at every line boundary that starts scan position 0, including the first boundary after reset. It is stable at all other times.
- R10: Each line issues exactly two RAM requests on consecutive cycles, half 0 (`ramHalf` = 0) first and then half 1, both carrying the line address of the row that comes next. Read data is taken one cycle after each request, and the half-0 request comes four cycles before the new row becomes visible.
- R11: During reset, `comSel`, `segOn`, `acPhase` and `ramReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fastSel | input | 1 | Divider select: 1 gives 96 cycles per line, 0 gives 48 |
| shiftEdge | input | 1 | Line boundary on the rising (1) or falling (0) edge of `lineClk` |
| comDir | input | 1 | Common scan direction |
| segDir | input | 1 | Column-to-segment order within each half |
| dispOn | input | 1 | Display enable; 0 blanks all segments |
| startLine | input | 6 | RAM line shown on the first row of each frame |
| ramData | input | 64 | Read data, valid one cycle after a request |
| ramReq | output | 1 | RAM read request |
| ramHalf | output | 1 | Half being read: 0 for columns of segments 0..63, 1 for 64..127 |
| ramLine | output | 6 | RAM line address of the request |
| lineClk | output | 1 | Divided line clock |
| acPhase | output | 1 | Frame alternation signal |
| comSel | output | 64 | One-hot common select |
| segOn | output | 128 | Per-segment select level after mapping and blanking |

## Verification
The assertions assume that `fastSel` and `shiftEdge` are held steady while out of reset, and that the RAM model answers every request in the following cycle. The stimulus therefore changes those two inputs only while reset is held, and a bench memory model returns data with exactly one cycle of latency. Scroll position, scan direction, column order and display enable are changed at random cycles, including cycles next to line and frame boundaries. Directed phases start from line 0 and line 63 to cover counter wrap, and hold the display blanked across a frame.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Number of halves that the segment row is fetched in
  localparam int SCAN_HALVES = 2;

  // Strobes sent by the control to the datapath
  typedef struct packed {
    logic capEn;     // ramData holds a valid half this cycle
    logic capSel;    // which half is on ramData
    logic lineLoad;  // line boundary: move shadow into display latch
  } scan_strobe_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int ROWS     = 64,
  parameter int DIV_FAST = 96,
  parameter int DIV_SLOW = 48,
  localparam int LINE_AW = $clog2(ROWS),
  localparam int CW      = $clog2(DIV_FAST + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fastSel,
  input  logic               shiftEdge,
  input  logic [LINE_AW-1:0] startLine,
  output scan_strobe_t       strobes,
  output logic [LINE_AW-1:0] rowIdx,
  output logic               live,
  output logic               ramReq,
  output logic               ramHalf,
  output logic [LINE_AW-1:0] ramLine,
  output logic               lineClk,
  output logic               acPhase
);

  localparam logic [LINE_AW-1:0] LAST_ROW = LINE_AW'(ROWS - 1);

  logic [CW-1:0] divCnt;
  logic [CW-1:0] divLim;
  logic [CW-1:0] halfLim;
  logic [CW-1:0] advPt;
  logic          reqLo;
  logic          reqHi;
  logic          lineLoad;
  logic          lastRow;
  logic [LINE_AW-1:0] lineAddr;
  logic [LINE_AW-1:0] pendLine;
  logic [LINE_AW-1:0] nextLine;
  logic          capReg;
  logic          capSelReg;

  // Divider: length of a line in oscillator cycles
  assign divLim  = fastSel ? CW'(DIV_FAST) : CW'(DIV_SLOW);
  assign halfLim = divLim >> 1;
  // Line boundary lands on the chosen edge of the line clock
  assign advPt   = shiftEdge ? (divLim - CW'(1)) : (halfLim - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt >= divLim - CW'(1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + CW'(1);
    end
  end

  assign lineClk  = (divCnt < halfLim);
  assign reqLo    = (divCnt == advPt - CW'(3));
  assign reqHi    = (divCnt == advPt - CW'(2));
  assign lineLoad = (divCnt == advPt);

  // Line address of the row that follows the current one
  assign lastRow  = (rowIdx == LAST_ROW);
  always_comb begin
    if (lastRow) begin
      nextLine = startLine;
    end else if (lineAddr == LAST_ROW) begin
      nextLine = '0;
    end else begin
      nextLine = lineAddr + LINE_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLine <= '0;
    end else if (reqLo) begin
      pendLine <= nextLine;
    end
  end

  assign ramReq  = reqLo | reqHi;
  assign ramHalf = reqHi;
  assign ramLine = reqLo ? nextLine : pendLine;

  // Read data arrives one cycle after the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg    <= 1'b0;
      capSelReg <= 1'b0;
    end else begin
      capReg    <= ramReq;
      capSelReg <= ramHalf;
    end
  end

  always_comb begin
    strobes.capEn    = capReg;
    strobes.capSel   = capSelReg;
    strobes.lineLoad = lineLoad;
  end

  // Row position, line counter and frame alternation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx   <= LAST_ROW;
      lineAddr <= '0;
      live     <= 1'b0;
      acPhase  <= 1'b0;
    end else if (lineLoad) begin
      rowIdx   <= lastRow ? '0 : rowIdx + LINE_AW'(1);
      lineAddr <= pendLine;
      live     <= 1'b1;
      if (lastRow) begin
        acPhase <= ~acPhase;
      end
    end
  end

  // R10
  req_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && ramHalf) |-> ($past(ramReq) && !$past(ramHalf)));

  // R10
  req_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && ramHalf) |-> (ramLine == $past(ramLine)));

  // R9
  ac_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acPhase != $past(acPhase)) |-> (rowIdx == '0 && $past(strobes.lineLoad)));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.lineLoad) && rowIdx != '0) |->
      (lineAddr == (($past(lineAddr) == LAST_ROW) ? '0 : $past(lineAddr) + LINE_AW'(1))));

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < divLim);

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int ROWS      = 64,
  parameter int HALF_COLS = 64,
  localparam int LINE_AW  = $clog2(ROWS),
  localparam int SEGS     = SCAN_HALVES * HALF_COLS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scan_strobe_t         strobes,
  input  logic [LINE_AW-1:0]   rowIdx,
  input  logic                 live,
  input  logic                 comDir,
  input  logic                 segDir,
  input  logic                 dispOn,
  input  logic [HALF_COLS-1:0] ramData,
  output logic [ROWS-1:0]      comSel,
  output logic [SEGS-1:0]      segOn
);

  logic [SCAN_HALVES-1:0][HALF_COLS-1:0] shadow;
  logic [SCAN_HALVES-1:0][HALF_COLS-1:0] dispLat;
  logic [SEGS-1:0]                       mapped;

  // Shadow capture per half, then transfer at the line boundary
  for (genvar h = 0; h < SCAN_HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[h]  <= '0;
        dispLat[h] <= '0;
      end else begin
        if (strobes.capEn && strobes.capSel == 1'(h)) begin
          shadow[h] <= ramData;
        end
        if (strobes.lineLoad) begin
          dispLat[h] <= shadow[h];
        end
      end
    end

    // Column order inside each half
    for (genvar c = 0; c < HALF_COLS; c++) begin : g_col
      assign mapped[h*HALF_COLS + c] =
        segDir ? dispLat[h][c] : dispLat[h][HALF_COLS-1-c];
    end
  end

  assign segOn = dispOn ? mapped : '0;

  // One-hot common select, direction chosen by comDir
  for (genvar i = 0; i < ROWS; i++) begin : g_com
    assign comSel[i] = live &&
      (comDir ? (rowIdx == LINE_AW'(i)) : (rowIdx == LINE_AW'(ROWS-1-i)));
  end

  // R1
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSel));

  // R1
  com_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    live |-> ($countones(comSel) == 1));

  // R4
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.lineLoad) |-> $stable(dispLat));

  // R4
  com_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobes.lineLoad) && $stable(comDir)) |-> $stable(comSel));

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import scan_pkg::*;
#(
  parameter int ROWS      = 64,
  parameter int HALF_COLS = 64,
  parameter int DIV_FAST  = 96,
  parameter int DIV_SLOW  = 48,
  localparam int LINE_AW  = $clog2(ROWS),
  localparam int SEGS     = SCAN_HALVES * HALF_COLS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fastSel,
  input  logic                 shiftEdge,
  input  logic                 comDir,
  input  logic                 segDir,
  input  logic                 dispOn,
  input  logic [LINE_AW-1:0]   startLine,
  input  logic [HALF_COLS-1:0] ramData,
  output logic                 ramReq,
  output logic                 ramHalf,
  output logic [LINE_AW-1:0]   ramLine,
  output logic                 lineClk,
  output logic                 acPhase,
  output logic [ROWS-1:0]      comSel,
  output logic [SEGS-1:0]      segOn
);

  scan_strobe_t       strobes;
  logic [LINE_AW-1:0] rowIdx;
  logic               live;

  scan_ctrl #(
    .ROWS     (ROWS),
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fastSel   (fastSel),
    .shiftEdge (shiftEdge),
    .startLine (startLine),
    .strobes   (strobes),
    .rowIdx    (rowIdx),
    .live      (live),
    .ramReq    (ramReq),
    .ramHalf   (ramHalf),
    .ramLine   (ramLine),
    .lineClk   (lineClk),
    .acPhase   (acPhase)
  );

  scan_datapath #(
    .ROWS      (ROWS),
    .HALF_COLS (HALF_COLS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rowIdx  (rowIdx),
    .live    (live),
    .comDir  (comDir),
    .segDir  (segDir),
    .dispOn  (dispOn),
    .ramData (ramData),
    .comSel  (comSel),
    .segOn   (segOn)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!ramReq && !acPhase && comSel == '0 && segOn == '0));

endmodule

// File: tb/lcd_row_scan_test.sv
`timescale 1ns/1ps
module lcd_row_scan_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fastSel = 1'b0;
  logic         shiftEdge = 1'b1;
  logic         comDir = 1'b1;
  logic         segDir = 1'b1;
  logic         dispOn = 1'b1;
  logic [5:0]   startLine = '0;
  logic [63:0]  ramData = '0;
  logic         ramReq;
  logic         ramHalf;
  logic [5:0]   ramLine;
  logic         lineClk;
  logic         acPhase;
  logic [63:0]  comSel;
  logic [127:0] segOn;

  always #2.5 clk = ~clk;

  lcd_row_scan uut (
    .clk(clk), .rstN(rstN), .fastSel(fastSel), .shiftEdge(shiftEdge),
    .comDir(comDir), .segDir(segDir), .dispOn(dispOn), .startLine(startLine),
    .ramData(ramData), .ramReq(ramReq), .ramHalf(ramHalf), .ramLine(ramLine),
    .lineClk(lineClk), .acPhase(acPhase), .comSel(comSel), .segOn(segOn)
  );

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  holdBlank = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] ramWord(int line, int half);
    logic [63:0] v;
    v = 64'h9E3779B97F4A7C15 * 64'(line * 2 + half + 1);
    v = v ^ (v >> 29) ^ 64'h5A17C3E0_0F1E2D3C;
    return v;
  endfunction

  function automatic logic [127:0] mapSeg(logic [63:0] lo, logic [63:0] hi, logic adc);
    logic [127:0] r;
    for (int s = 0; s < 128; s++) begin
      int c;
      int col;
      c   = s % 64;
      col = adc ? c : 63 - c;
      r[s] = (s < 64) ? lo[col] : hi[col];
    end
    return r;
  endfunction

  function automatic logic [63:0] expCom(bit on, int row, logic dir);
    logic [63:0] r;
    r = '0;
    if (on) r[dir ? row : 63 - row] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // Bench model state
  bit          started;
  int          row, line, lastStart, nextStart, reqCyc, reqLine, lineLen;
  bit          pclkCfg, expM, prevLc;
  logic [63:0] wLo, wHi, pendData;

  always @(negedge clk) begin
    // Memory model: one cycle latency
    ramData  = pendData;
    pendData = ramReq ? ramWord(int'(ramLine), int'(ramHalf)) : {$urandom, $urandom};

    if (!rstN) begin
      // R11 reset state
      check(comSel == '0 && segOn == '0 && !acPhase && !ramReq, "R11",
            {acPhase, ramReq, comSel[61:0], segOn[63:0]}, '0);
      started   = 1'b0;
      row       = 63;
      line      = 0;
      expM      = 1'b0;
      nextStart = -1;
      lastStart = 0;
      reqCyc    = -10;
      reqLine   = 0;
      lineLen   = fastSel ? 96 : 48;
      pclkCfg   = shiftEdge;
      wLo       = '0;
      wHi       = '0;
    end else begin
      if (ramReq && !ramHalf) begin
        int expNext;
        expNext = (!started || row == 63) ? int'(startLine) : (line + 1) % 64;
        // R3 address of the next row
        check(int'(ramLine) == expNext, "R3", 128'(ramLine), 128'(expNext));
        // R2 line period
        if (started) check(cyc + 4 - lastStart == lineLen, "R2",
                           128'(cyc + 4 - lastStart), 128'(lineLen));
        reqCyc    = cyc;
        reqLine   = int'(ramLine);
        nextStart = cyc + 4;
      end
      if (ramReq && ramHalf) begin
        // R10 second half on the next cycle, same line
        check(cyc == reqCyc + 1 && int'(ramLine) == reqLine, "R10",
              128'(ramLine), 128'(reqLine));
      end
      if (cyc == nextStart) begin
        row     = (row == 63) ? 0 : row + 1;
        line    = reqLine;
        wLo     = ramWord(line, 0);
        wHi     = ramWord(line, 1);
        if (row == 0) expM = ~expM;
        started   = 1'b1;
        lastStart = cyc;
        // R7 boundary on the selected line clock edge
        check(pclkCfg ? (lineClk && !prevLc) : (!lineClk && prevLc), "R7",
              128'({prevLc, lineClk}), 128'(pclkCfg ? 2'b01 : 2'b10));
      end
      if (started && cyc - lastStart > 2 * lineLen) begin
        check(1'b0, "R2 line watchdog", 128'(cyc - lastStart), 128'(lineLen));
        lastStart = cyc;
      end
      // R1 R5 common select
      check(comSel == expCom(started, row, comDir), "R1/R5",
            128'(comSel), 128'(expCom(started, row, comDir)));
      // R4 R6 R8 segments
      begin
        logic [127:0] es;
        es = (started && dispOn) ? mapSeg(wLo, wHi, segDir) : '0;
        check(segOn == es, "R4/R6/R8", segOn, es);
      end
      // R9 frame alternation
      check(acPhase == expM, "R9", 128'(acPhase), 128'(expM));
    end
    prevLc = lineClk;
  end

  task automatic runPhase(bit fs, bit pc, int sl, int n, bit blankStart);
    @(posedge clk); #1;
    rstN      = 1'b0;
    fastSel   = fs;
    shiftEdge = pc;
    startLine = 6'(sl);
    dispOn    = ~blankStart;
    holdBlank = blankStart;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (holdBlank && i == n / 2) begin
        holdBlank = 1'b0;
        dispOn    = 1'b1;
      end
      if (!holdBlank && ($urandom % 97) == 0) dispOn = ~dispOn;
      if (($urandom % 300) == 0) segDir = ~segDir;
      if (($urandom % 300) == 0) comDir = ~comDir;
      if (($urandom % 150) == 0) startLine = 6'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd8675309));
    pendData = '0;
    prevLc   = 1'b0;
    // Directed start line 0, slow divider, rising edge
    runPhase(1'b0, 1'b1, 0, 7000, 1'b0);
    // Directed start line 63 (wrap), slow divider, falling edge
    runPhase(1'b0, 1'b0, 63, 7000, 1'b0);
    // Random start, fast divider, rising edge
    runPhase(1'b1, 1'b1, int'($urandom % 64), 13000, 1'b0);
    // Blanked for a frame then enabled, fast divider, falling edge
    runPhase(1'b1, 1'b0, 5, 13000, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual %0d expected below 150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule